// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns one asynchronous serial input line into received characters. The line passes through a synchroniser. A falling edge on the synchronised line arms the frame machine. After that, every bit is sampled once, at its centre. The sample points are counted in ticks of an external strobe that runs at sixteen times the bit rate. Five line-control inputs describe the frame: the character length, three parity inputs (on/off, even/odd and stick) and a buffering mode.

Each finished frame becomes one buffer entry. An entry holds the character, right-aligned, and three flags: parity error, framing error and line break. A consumer drains the buffer through a valid/ready pair. In buffered mode the buffer is several entries deep. In character mode it holds a single entry. A character that arrives when the buffer is full is discarded, and a sticky overrun indication is raised.

The count of stop bits used by the sending side does not matter here. Only the first stop position is ever examined, so no input selects it.

Top module: `uartRxCore`

## Requirements
- R1: `cfgWordLen` selects the data bits per frame: 0→5, 1→6, 2→7, 3→8. Bits arrive least significant first. `rdData` bits above the selected length read 0.
- R2: With `cfgParityEn`=0 the stop position follows the last data bit directly, and `rdParityErr` is always 0.
- R3: With `cfgParityEn`=1 and `cfgStickSel`=0, the received parity bit is checked as follows. With `cfgEvenSel`=1, data plus parity must hold an even count of ones. With `cfgEvenSel`=0, the count must be odd. A violation sets `rdParityErr`.
- R4: With `cfgParityEn`=1 and `cfgStickSel`=1, the received parity bit must equal the inverse of `cfgEvenSel`. Any other value sets `rdParityErr`.
- R5: Only the first stop position is checked. A low there sets `rdFrameErr`. Frames with one or two stop bits, and frames sent back to back, are all accepted.
- R6: A frame whose data, parity and first stop positions are all low stores exactly one entry. That entry has `rdData`=0, `rdBreak`=1 and `rdFrameErr`=1. No further frame starts until the line has returned high.
- R7: A start is taken from a falling edge on the synchronised line. The line is re-checked 8 ticks later. If it is high again there, the start is discarded and nothing is stored. Each later bit is sampled every 16 ticks.
- R8: With `cfgFifoMode`=1 the buffer holds DEPTH (default 4) entries. A character that arrives while the buffer is full is dropped and sets `overrun`. `overrun` stays set until the next accepted read, which clears it.
- R9: With `cfgFifoMode`=0 the buffer holds one entry. A second character that arrives before that entry is read is dropped and sets `overrun`.
- R10: After reset `rdValid` and `overrun` are 0. An offered entry, with its flags, stays unchanged until `rdReady` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick16 | input | 1 | One-cycle strobe at 16× the bit rate |
| rxdIn | input | 1 | Asynchronous serial input, idle high |
| cfgWordLen | input | 2 | Character length code |
| cfgParityEn | input | 1 | Parity bit present and checked |
| cfgEvenSel | input | 1 | Even parity select / stick value select |
| cfgStickSel | input | 1 | Stick parity select |
| cfgFifoMode | input | 1 | 1: multi-entry buffer, 0: single holding entry |
| rdValid | output | 1 | Buffer head holds an entry |
| rdReady | input | 1 | Consumer accepts the head entry |
| rdData | output | 8 | Head character, right-aligned |
| rdParityErr | output | 1 | Head entry parity error |
| rdFrameErr | output | 1 | Head entry framing error |
| rdBreak | output | 1 | Head entry is a line break |
| overrun | output | 1 | Sticky character-dropped indication |

## Verification
The cycle-level assertions cover the read port and the buffer:
- the reset state;
- that the head entry stays steady until it is accepted;
- that `overrun` stays set and clears on a read;
- that the buffer never fills beyond its depth;
- that every break entry carries zero data and a framing error.

Only the bench scenarios can show the frame-level behaviour: correct assembly for every character length, all five parity settings, rejection of a false start, the single entry for a long break, and the choice of which character is dropped when the buffer is full. Those need whole serial waveforms and an independent parity computation.

// File: rtl/uartRxPkg.sv
package uartRxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_HOLD
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearFrame;
    logic shiftBit;
    logic takeParity;
    logic takeStop;
  } rxStrobe_t;

  typedef struct packed {
    logic       brk;
    logic       frameErr;
    logic       parErr;
    logic [7:0] data;
  } rxEntry_t;

  function automatic logic [3:0] wordBits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/rxCtrl.sv
module rxCtrl
  import uartRxPkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxS,
  input  logic       rxFall,
  input  logic       allZero,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  output rxStrobe_t  strobe
);

  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);

  rxState_e      state;
  logic [CW-1:0] tickCnt;
  logic [2:0]    bitCnt;
  logic          atSample;
  logic          lastData;
  logic [3:0]    nBits;

  assign nBits    = wordBits(wordLen);
  assign lastData = ({1'b0, bitCnt} == nBits - 4'd1);
  assign atSample = tick && (tickCnt == ((state == ST_START) ? HALF_LAST : FULL_LAST));

  always_comb begin
    strobe            = '0;
    strobe.clearFrame = (state == ST_START)  && atSample && !rxS;
    strobe.shiftBit   = (state == ST_DATA)   && atSample;
    strobe.takeParity = (state == ST_PARITY) && atSample;
    strobe.takeStop   = (state == ST_STOP)   && atSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          bitCnt  <= '0;
          if (rxFall) state <= ST_START;
        end
        ST_HOLD: begin
          if (rxS) state <= ST_IDLE;
        end
        default: begin
          if (tick) begin
            tickCnt <= atSample ? '0 : tickCnt + 1'b1;
            if (atSample) begin
              unique case (state)
                ST_START: state <= rxS ? ST_IDLE : ST_DATA;
                ST_DATA: begin
                  bitCnt <= bitCnt + 3'd1;
                  if (lastData) state <= parityEn ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: state <= ST_STOP;
                ST_STOP:   state <= (allZero && !rxS) ? ST_HOLD : ST_IDLE;
                default:   state <= ST_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rxDatapath.sv
module rxDatapath
  import uartRxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxdIn,
  input  rxStrobe_t  strobe,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       evenSel,
  input  logic       stickSel,
  output logic       rxS,
  output logic       rxFall,
  output logic       allZero,
  output rxEntry_t   entry
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevRx;
  logic [7:0]             shiftReg;
  logic                   parBit;
  logic [7:0]             aligned;
  logic [3:0]             nBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxdIn};
  end

  assign rxS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevRx <= 1'b1;
    else       prevRx <= rxS;
  end

  assign rxFall = prevRx && !rxS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      allZero  <= 1'b1;
    end else if (strobe.clearFrame) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      allZero  <= 1'b1;
    end else if (strobe.shiftBit) begin
      shiftReg <= {rxS, shiftReg[7:1]};
      allZero  <= allZero && !rxS;
    end else if (strobe.takeParity) begin
      parBit  <= rxS;
      allZero <= allZero && !rxS;
    end
  end

  assign nBits   = wordBits(wordLen);
  assign aligned = shiftReg >> (4'd8 - nBits);

  always_comb begin
    entry.data     = aligned;
    entry.frameErr = !rxS;
    entry.brk      = allZero && !rxS;
    if (!parityEn)     entry.parErr = 1'b0;
    else if (stickSel) entry.parErr = (parBit == evenSel);
    else               entry.parErr = (^aligned) ^ parBit ^ !evenSel;
  end

endmodule

// File: rtl/rxBuffer.sv
module rxBuffer
  import uartRxPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pushEn,
  input  rxEntry_t               pushEntry,
  input  logic                   fifoMode,
  input  logic                   popReady,
  output rxEntry_t               headEntry,
  output logic                   headValid,
  output logic                   overrun,
  output logic [$clog2(DEPTH):0] fill
);

  localparam int PW = $clog2(DEPTH);

  rxEntry_t      mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [PW:0]   capacity;
  logic          pop;
  logic          accept;
  logic          drop;

  assign capacity  = fifoMode ? (PW+1)'(DEPTH) : (PW+1)'(1);
  assign headValid = (fill != '0);
  assign pop       = headValid && popReady;
  assign accept    = pushEn && ((fill < capacity) || pop);
  assign drop      = pushEn && !accept;
  assign headEntry = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (accept) mem[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fill    <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;
      if (pop)    rdPtr <= rdPtr + 1'b1;
      case ({accept, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (drop)     overrun <= 1'b1;
      else if (pop) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/uartRxCore.sv
module uartRxCore
  import uartRxPkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick16,
  input  logic       rxdIn,
  input  logic [1:0] cfgWordLen,
  input  logic       cfgParityEn,
  input  logic       cfgEvenSel,
  input  logic       cfgStickSel,
  input  logic       cfgFifoMode,
  output logic       rdValid,
  input  logic       rdReady,
  output logic [7:0] rdData,
  output logic       rdParityErr,
  output logic       rdFrameErr,
  output logic       rdBreak,
  output logic       overrun
);

  rxStrobe_t              strobe;
  rxEntry_t               newEntry;
  rxEntry_t               headEntry;
  logic                   rxS;
  logic                   rxFall;
  logic                   allZero;
  logic [$clog2(DEPTH):0] bufFill;

  rxCtrl #(.OVERSAMPLE(OVERSAMPLE)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (baudTick16),
    .rxS      (rxS),
    .rxFall   (rxFall),
    .allZero  (allZero),
    .wordLen  (cfgWordLen),
    .parityEn (cfgParityEn),
    .strobe   (strobe)
  );

  rxDatapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxdIn    (rxdIn),
    .strobe   (strobe),
    .wordLen  (cfgWordLen),
    .parityEn (cfgParityEn),
    .evenSel  (cfgEvenSel),
    .stickSel (cfgStickSel),
    .rxS      (rxS),
    .rxFall   (rxFall),
    .allZero  (allZero),
    .entry    (newEntry)
  );

  rxBuffer #(.DEPTH(DEPTH)) i_buf (
    .clk       (clk),
    .rstN      (rstN),
    .pushEn    (strobe.takeStop),
    .pushEntry (newEntry),
    .fifoMode  (cfgFifoMode),
    .popReady  (rdReady),
    .headEntry (headEntry),
    .headValid (rdValid),
    .overrun   (overrun),
    .fill      (bufFill)
  );

  assign rdData      = headEntry.data;
  assign rdParityErr = headEntry.parErr;
  assign rdFrameErr  = headEntry.frameErr;
  assign rdBreak     = headEntry.brk;

endmodule

// File: rtl/uartRxCoreChecker.sv
module uartRxCoreChecker #(
  parameter int DEPTH = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rdValid,
  input logic                   rdReady,
  input logic [7:0]             rdData,
  input logic                   rdParityErr,
  input logic                   rdFrameErr,
  input logic                   rdBreak,
  input logic                   overrun,
  input logic [$clog2(DEPTH):0] bufFill
);

  // R10: reset empties the buffer and clears overrun
  a_r10_reset_state: assert property (@(posedge clk) !rstN |=> (!rdValid && !overrun));

  // R10: head entry held until accepted
  a_r10_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData) && $stable(rdParityErr)
                              && $stable(rdFrameErr) && $stable(rdBreak)));

  // R8: overrun is sticky until a read
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !(rdValid && rdReady)) |=> overrun);

  // R8: a read clears overrun
  a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady) |=> !overrun);

  // R8: occupancy bounded by depth
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    bufFill <= ($clog2(DEPTH)+1)'(DEPTH));

  // R6: a break entry carries zero data and a framing error
  a_r6_break_entry: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdBreak) |-> (rdData == 8'h00 && rdFrameErr));

endmodule

bind uartRxCore uartRxCoreChecker #(.DEPTH(DEPTH)) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .rdValid     (rdValid),
  .rdReady     (rdReady),
  .rdData      (rdData),
  .rdParityErr (rdParityErr),
  .rdFrameErr  (rdFrameErr),
  .rdBreak     (rdBreak),
  .overrun     (overrun),
  .bufFill     (bufFill)
);

// File: tb/test_uartRxCore.sv
module test_uartRxCore;

  localparam int BIT_CLKS = 32;  // tick every 2 clocks, 16 ticks per bit

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick16 = 1'b0;
  logic       rxdIn = 1'b1;
  logic [1:0] cfgWordLen = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic       cfgEvenSel = 1'b0;
  logic       cfgStickSel = 1'b0;
  logic       cfgFifoMode = 1'b1;
  logic       rdValid;
  logic       rdReady = 1'b0;
  logic [7:0] rdData;
  logic       rdParityErr;
  logic       rdFrameErr;
  logic       rdBreak;
  logic       overrun;

  int checks = 0;
  int fails = 0;

  uartRxCore i_uartRxCore (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick16  (baudTick16),
    .rxdIn       (rxdIn),
    .cfgWordLen  (cfgWordLen),
    .cfgParityEn (cfgParityEn),
    .cfgEvenSel  (cfgEvenSel),
    .cfgStickSel (cfgStickSel),
    .cfgFifoMode (cfgFifoMode),
    .rdValid     (rdValid),
    .rdReady     (rdReady),
    .rdData      (rdData),
    .rdParityErr (rdParityErr),
    .rdFrameErr  (rdFrameErr),
    .rdBreak     (rdBreak),
    .overrun     (overrun)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      baudTick16 = ~baudTick16;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic driveBit(input logic v);
    rxdIn = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nb, input logic pen, input logic pb,
                           input logic stopV, input int nStop, input int idle);
    driveBit(1'b0);
    for (int i = 0; i < nb; i++) driveBit(d[i]);
    if (pen) driveBit(pb);
    driveBit(stopV);
    for (int i = 1; i < nStop; i++) driveBit(1'b1);
    for (int i = 0; i < idle; i++) driveBit(1'b1);
  endtask

  task automatic popChar();
    @(negedge clk);
    rdReady = 1'b1;
    @(negedge clk);
    rdReady = 1'b0;
  endtask

  task automatic expectChar(input string tag, input logic [7:0] d, input logic pe,
                            input logic fe, input logic brk);
    check({tag, " valid"}, {31'd0, rdValid}, 32'd1);
    check({tag, " entry"}, {21'd0, rdBreak, rdFrameErr, rdParityErr, rdData},
          {21'd0, brk, fe, pe, d});
    popChar();
  endtask

  function automatic logic goodParity(input logic [7:0] d, input logic even, input logic stick);
    if (stick) return !even;
    return even ? (^d) : !(^d);
  endfunction

  initial begin
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h96};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 reset rdValid", {31'd0, rdValid}, 32'd0);
    check("R10 reset overrun", {31'd0, overrun}, 32'd0);

    // R1..R4 sweep over length, parity mode, data and parity corruption
    for (int wl = 0; wl < 4; wl++) begin
      for (int pm = 0; pm < 5; pm++) begin
        for (int di = 0; di < 5; di++) begin
          for (int bad = 0; bad < 2; bad++) begin
            logic [7:0] mask;
            logic [7:0] d;
            logic       pb;
            string      tag;
            if (pm == 0 && bad == 1) continue;
            cfgWordLen  = 2'(wl);
            cfgParityEn = (pm != 0);
            cfgEvenSel  = (pm == 1 || pm == 4);
            cfgStickSel = (pm >= 3);
            mask = 8'((9'd1 << (5 + wl)) - 9'd1);
            d    = pats[di] & mask;
            pb   = goodParity(d, cfgEvenSel, cfgStickSel) ^ bad[0];
            case (pm)
              0:       tag = "R1 R2 no-parity";
              1, 2:    tag = "R1 R3 even/odd";
              default: tag = "R1 R4 stick";
            endcase
            tag = $sformatf("%s wl=%0d pm=%0d d=%0h bad=%0d", tag, wl, pm, d, bad);
            sendFrame(pats[di], 5 + wl, cfgParityEn, pb, 1'b1, 1, 1);
            expectChar(tag, d, cfgParityEn & bad[0], 1'b0, 1'b0);
          end
        end
      end
    end

    cfgWordLen = 2'd3; cfgParityEn = 1'b0; cfgStickSel = 1'b0; cfgEvenSel = 1'b0;

    // R5 framing error on low first stop
    sendFrame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1, 2);
    expectChar("R5 framing", 8'h3C, 1'b0, 1'b1, 1'b0);

    // R5 two stop bits and back-to-back single stop frames
    sendFrame(8'h81, 8, 1'b0, 1'b0, 1'b1, 2, 1);
    expectChar("R5 two-stop", 8'h81, 1'b0, 1'b0, 1'b0);
    sendFrame(8'hC3, 8, 1'b0, 1'b0, 1'b1, 1, 0);
    sendFrame(8'h24, 8, 1'b0, 1'b0, 1'b1, 1, 1);
    expectChar("R5 back-to-back first", 8'hC3, 1'b0, 1'b0, 1'b0);
    expectChar("R5 back-to-back second", 8'h24, 1'b0, 1'b0, 1'b0);

    // R6 long break stores one entry
    rxdIn = 1'b0;
    repeat (25 * BIT_CLKS) @(negedge clk);
    rxdIn = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    expectChar("R6 break", 8'h00, 1'b0, 1'b1, 1'b1);
    check("R6 single break entry", {31'd0, rdValid}, 32'd0);
    sendFrame(8'h6E, 8, 1'b0, 1'b0, 1'b1, 1, 1);
    expectChar("R6 after break", 8'h6E, 1'b0, 1'b0, 1'b0);

    // R7 false start rejection
    rxdIn = 1'b0;
    repeat (8) @(negedge clk);
    rxdIn = 1'b1;
    repeat (14 * BIT_CLKS) @(negedge clk);
    check("R7 glitch stored nothing", {31'd0, rdValid}, 32'd0);
    sendFrame(8'h5B, 8, 1'b0, 1'b0, 1'b1, 1, 1);
    expectChar("R7 frame after glitch", 8'h5B, 1'b0, 1'b0, 1'b0);

    // R8 buffered mode overflow
    cfgFifoMode = 1'b1;
    for (int i = 1; i <= 5; i++) sendFrame(8'(i), 8, 1'b0, 1'b0, 1'b1, 1, 1);
    check("R8 overrun set", {31'd0, overrun}, 32'd1);
    for (int i = 1; i <= 4; i++) begin
      expectChar($sformatf("R8 fifo entry %0d", i), 8'(i), 1'b0, 1'b0, 1'b0);
      if (i == 1) check("R8 overrun cleared by read", {31'd0, overrun}, 32'd0);
    end
    check("R8 fifo drained", {31'd0, rdValid}, 32'd0);

    // R9 character mode single holding entry
    cfgFifoMode = 1'b0;
    sendFrame(8'h11, 8, 1'b0, 1'b0, 1'b1, 1, 1);
    check("R9 no overrun yet", {31'd0, overrun}, 32'd0);
    sendFrame(8'h22, 8, 1'b0, 1'b0, 1'b1, 1, 1);
    check("R9 overrun", {31'd0, overrun}, 32'd1);
    expectChar("R9 held entry", 8'h11, 1'b0, 1'b0, 1'b0);
    check("R9 second dropped", {31'd0, rdValid}, 32'd0);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

endmodule